// File: doc/BRIEF.md
# Conditional Branch Target Unit

This unit resolves the relative conditional branches of an 8-bit processor. Each cycle it takes the opcode byte, the signed 8-bit displacement byte, the four condition flags (negative, overflow, carry, zero) and the address of the instruction that follows the branch. From these it decides whether the opcode is one of the eight conditional branches and whether that branch is taken. It then produces the program counter the core should continue from.

The opcode itself encodes the condition. Bits 7..6 choose one of the four flags, and bit 5 gives the flag value that makes the branch go. A taken branch continues at the sequential address plus the sign-extended displacement, and the sum wraps at the address width. Every other case continues at the sequential address. All three results are registered, so they appear one clock after their inputs are presented, and reset clears them.

Top module: `branch_unit`

## Requirements
- R1: While `rstN` is low, `isBranch`, `taken` and `nextPc` are all zero.
- R2: `isBranch` is 1 exactly when the low five bits of the opcode equal 5'b10000 (opcodes 0x10, 0x30, 0x50, 0x70, 0x90, 0xB0, 0xD0, 0xF0).
- R3: For a branch opcode, bits 7..6 select the tested flag (00 negative, 01 overflow, 10 carry, 11 zero), and `taken` is 1 exactly when that flag equals opcode bit 5.
- R4: For an opcode outside the branch group, `taken` is 0 and `nextPc` equals `seqPc`, whatever the flags and displacement are.
- R5: When a branch is taken, `nextPc` equals `seqPc` plus the sign-extended displacement, modulo 2^16.
- R6: When a branch opcode's condition is false, `nextPc` equals `seqPc`.
- R7: The displacement is two's complement: 0x7F adds 127, 0x80 subtracts 128, and 0xFF subtracts 1.
- R8: Every output reflects the inputs sampled at the previous rising clock edge, with a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opcode | input | 8 | Instruction opcode byte |
| disp | input | 8 | Signed displacement byte |
| flagN | input | 1 | Negative flag |
| flagV | input | 1 | Overflow flag |
| flagC | input | 1 | Carry flag |
| flagZ | input | 1 | Zero flag |
| seqPc | input | 16 | Address of the instruction after the branch |
| isBranch | output | 1 | Opcode belongs to the conditional branch group |
| taken | output | 1 | Branch condition satisfied |
| nextPc | output | 16 | Program counter to continue from |

## Verification
The bench builds the unit with its default widths: a 16-bit address and an 8-bit displacement. It sweeps all 256 opcodes against all 16 flag combinations, so every condition pairing and every non-branch code is covered. The displacement and sequential address vary along the way. Separate directed vectors take the target sum across both ends of the 16-bit range, with the largest forward and backward displacements, so the wrap behaviour and the sign extension are checked at their limits.

// File: rtl/branch_unit_pkg.sv
package branch_unit_pkg;

  localparam int OP_W = 8;

  // Low five opcode bits shared by every member of the branch group.
  localparam logic [4:0] GROUP_CODE = 5'b10000;

  // Flag chosen by opcode bits 7..6.
  typedef enum logic [1:0] {
    FSEL_NEG   = 2'b00,
    FSEL_OVF   = 2'b01,
    FSEL_CARRY = 2'b10,
    FSEL_ZERO  = 2'b11
  } flagSel_e;

  // Strobes handed from the decision logic to the datapath.
  typedef struct packed {
    logic isBranch;
    logic takeBranch;
  } brStrobe_t;

endpackage

// File: rtl/branch_cond_ctrl.sv
module branch_cond_ctrl
  import branch_unit_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  input  logic            flagN,
  input  logic            flagV,
  input  logic            flagC,
  input  logic            flagZ,
  output brStrobe_t       strobes
);

  localparam int NUM_FLAGS = 4;

  logic [NUM_FLAGS-1:0] flagVec;
  logic [NUM_FLAGS-1:0] condHit;
  logic                 inGroup;
  logic                 wantSet;

  // The index order follows the selector code in opcode bits 7..6.
  assign flagVec = {flagZ, flagC, flagV, flagN};
  assign inGroup = (opcode[4:0] == GROUP_CODE);
  assign wantSet = opcode[5];

  // Each flag gets a comparator that fires only when its selector is active.
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cond
    assign condHit[i] = (opcode[7:6] == 2'(i)) && (flagVec[i] == wantSet);
  end

  always_comb begin
    strobes            = '0;
    strobes.isBranch   = inGroup;
    strobes.takeBranch = inGroup && (|condHit);
  end

  // R4: a take strobe is never raised for an opcode outside the group.
  p_take_in_group_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeBranch |-> (opcode[4:0] == GROUP_CODE));

  // R3: the zero-flag branches follow the zero flag against opcode bit 5.
  p_zero_cond_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.isBranch && (opcode[7:6] == FSEL_ZERO)) |->
      (strobes.takeBranch == (flagZ == opcode[5])));

  // R3: the carry-flag branches follow the carry flag.
  p_carry_cond_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.isBranch && (opcode[7:6] == FSEL_CARRY)) |->
      (strobes.takeBranch == (flagC == opcode[5])));

endmodule

// File: rtl/branch_target_dp.sv
module branch_target_dp
  import branch_unit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  brStrobe_t         strobes,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] seqPc,
  output logic              isBranch,
  output logic              taken,
  output logic [ADDR_W-1:0] nextPc
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] targetPc;
  logic [ADDR_W-1:0] pcSel;

  // Sign extension, with a plain copy when the widths are equal.
  if (EXT_W > 0) begin : g_sext
    assign dispExt = {{EXT_W{disp[DISP_W-1]}}, disp};
  end else begin : g_nosext
    assign dispExt = disp[ADDR_W-1:0];
  end

  // The sum wraps naturally at ADDR_W bits.
  assign targetPc = seqPc + dispExt;
  assign pcSel    = strobes.takeBranch ? targetPc : seqPc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isBranch <= 1'b0;
      taken    <= 1'b0;
      nextPc   <= '0;
    end else begin
      isBranch <= strobes.isBranch;
      taken    <= strobes.takeBranch;
      nextPc   <= pcSel;
    end
  end

  // R6: a strobe that does not take the branch leads to the sequential address one cycle later.
  p_fallthrough_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.takeBranch |=> (nextPc == $past(seqPc)));

  // R5: a taken strobe leads to the displaced address one cycle later.
  p_target_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeBranch |=> (nextPc == ADDR_W'($past(seqPc) + $past(dispExt))));

  // R4: the registered outputs never show taken without branch.
  p_taken_branch_r4: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> isBranch);

  // R8: the registered branch flag follows the strobe with one cycle of latency.
  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.isBranch |=> isBranch);

endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import branch_unit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DISP_W-1:0] disp,
  input  logic              flagN,
  input  logic              flagV,
  input  logic              flagC,
  input  logic              flagZ,
  input  logic [ADDR_W-1:0] seqPc,
  output logic              isBranch,
  output logic              taken,
  output logic [ADDR_W-1:0] nextPc
);

  brStrobe_t strobes;

  branch_cond_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .opcode  (opcode),
    .flagN   (flagN),
    .flagV   (flagV),
    .flagC   (flagC),
    .flagZ   (flagZ),
    .strobes (strobes)
  );

  branch_target_dp #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .disp     (disp),
    .seqPc    (seqPc),
    .isBranch (isBranch),
    .taken    (taken),
    .nextPc   (nextPc)
  );

  // R1: all outputs are held at zero one cycle into reset.
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!isBranch && !taken && (nextPc == '0)));

endmodule

// File: tb/branch_unit_tb_top.sv
module branch_unit_tb_top;

  localparam int  CLK_PERIOD = 10;
  localparam int  ADDR_W     = 16;
  localparam int  DISP_W     = 8;
  localparam int  WATCHDOG   = 200000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [7:0]        opcode = '0;
  logic [DISP_W-1:0] disp = '0;
  logic              flagN = 1'b0, flagV = 1'b0, flagC = 1'b0, flagZ = 1'b0;
  logic [ADDR_W-1:0] seqPc = '0;
  logic              isBranch, taken;
  logic [ADDR_W-1:0] nextPc;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_unit #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) dut_i (
    .clk(clk), .rstN(rstN), .opcode(opcode), .disp(disp),
    .flagN(flagN), .flagV(flagV), .flagC(flagC), .flagZ(flagZ),
    .seqPc(seqPc), .isBranch(isBranch), .taken(taken), .nextPc(nextPc)
  );

  task automatic check(input string req, input logic [ADDR_W-1:0] act,
                       input logic [ADDR_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s op=%02h disp=%02h flags(NVCZ)=%b%b%b%b pc=%04h: actual %04h expected %04h",
               req, opcode, disp, flagN, flagV, flagC, flagZ, seqPc, act, exp);
    end
  endtask

  // Drive a vector on the falling edge, let one rising edge register it,
  // and compare on the next falling edge against a model of R2..R7.
  task automatic apply(input logic [7:0] op, input logic [DISP_W-1:0] d,
                       input logic [3:0] nvcz, input logic [ADDR_W-1:0] pc);
    logic expBr, expTk, sel;
    logic [ADDR_W-1:0] expPc;
    opcode = op; disp = d; seqPc = pc;
    {flagN, flagV, flagC, flagZ} = nvcz;
    expBr = (op[4:0] == 5'b10000);
    case (op[7:6])
      2'b00:   sel = nvcz[3];
      2'b01:   sel = nvcz[2];
      2'b10:   sel = nvcz[1];
      default: sel = nvcz[0];
    endcase
    expTk = expBr && (sel == op[5]);
    expPc = expTk ? ADDR_W'(int'(pc) + int'($signed(d))) : pc;
    @(negedge clk);
    check("R2 isBranch", {15'b0, isBranch}, {15'b0, expBr});
    check(expBr ? "R3 taken" : "R4 taken", {15'b0, taken}, {15'b0, expTk});
    check(expTk ? "R5 nextPc" : (expBr ? "R6 nextPc" : "R4 nextPc"), nextPc, expPc);
  endtask

  initial begin
    // R1: outputs are zero during reset, even with branch-like inputs.
    opcode = 8'hF0; flagZ = 1'b1; disp = 8'h10; seqPc = 16'h1234;
    repeat (3) @(negedge clk);
    check("R1 isBranch", {15'b0, isBranch}, '0);
    check("R1 taken", {15'b0, taken}, '0);
    check("R1 nextPc", nextPc, '0);
    rstN = 1'b1;

    // R2/R3/R4/R6 and R8: all opcodes against all flag combinations.
    for (int op = 0; op < 256; op++) begin
      for (int f = 0; f < 16; f++) begin
        apply(8'(op), 8'(op * 7 + f * 29), 4'(f), 16'(op * 257 + f * 4099));
      end
    end

    // R5/R7: wrap and extreme displacements.
    apply(8'hF0, 8'h01, 4'b0001, 16'hFFFF);  // wraps to 0000
    apply(8'hD0, 8'h80, 4'b0000, 16'h0000);  // wraps to FF80
    apply(8'h90, 8'h7F, 4'b0000, 16'hFF90);  // wraps to 000F
    apply(8'hB0, 8'hFF, 4'b0010, 16'h0000);  // -1 wraps to FFFF
    apply(8'h10, 8'h80, 4'b0000, 16'h8000);  // R7: -128 gives 7F80
    apply(8'h70, 8'h7F, 4'b0100, 16'h7F81);  // R7: +127 gives 8000
    apply(8'h30, 8'h80, 4'b0111, 16'h0050);  // not taken, stays put

    // R8: back-to-back vectors each appear exactly one cycle later.
    apply(8'hF0, 8'h02, 4'b0001, 16'h4000);
    apply(8'hEA, 8'h02, 4'b0001, 16'h5000);
    apply(8'hF0, 8'hFE, 4'b0001, 16'h6000);

    // R1: reassert reset after activity.
    rstN = 1'b0;
    @(negedge clk);
    check("R1 isBranch", {15'b0, isBranch}, '0);
    check("R1 taken", {15'b0, taken}, '0);
    check("R1 nextPc", nextPc, '0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule